// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. After reset it takes the memory array from an unknown power-on state to a state where it is ready for traffic. It drives the command pins (chip select, row strobe, column strobe, write enable), the address and bank pins, the clock enable and the byte masks.

The sequence starts with a long pause of NOP cycles. During the pause the clock enable and all data masks are held high. The block then issues a precharge of every bank, and after that a configurable number of auto-refresh commands and one mode register load. A parameter decides whether the refresh group comes before or after the mode load. Each command is followed by its own recovery time, counted in clock cycles. A separate, longer settling count covers the lock time of the module clock generator.

The ready flag rises only when two conditions are both met: the last recovery time has ended, and the settling count has expired. The flag then stays high until the next reset. The operation code for the mode register is taken from an input port and captured once, on the first clock edge after reset is released.

Top module: `sdram_boot_seq`

## Requirements
- R1: Let bus cycle n be the interval that follows the n-th rising edge after reset release, with the interval before that first edge counted as n = 0. In bus cycles 0 to PAUSE_CYC-1 the pins carry NOP. NOP is encoded as {cs_n, ras_n, cas_n, we_n} = 0111.
- R2: In bus cycle PAUSE_CYC the block issues a precharge of all banks, encoded as 0010. For this command addr_o bit 10 is 1, all other address bits are 0, and ba_o is 0.
- R3: The command that follows the precharge appears exactly T_RP cycles after it.
- R4: Exactly REF_CNT auto-refresh commands are issued, encoded as 0001. Consecutive refreshes are T_RC cycles apart, and a refresh is followed by at least T_RC cycles before any later command or before ready.
- R5: Exactly one mode register load is issued, encoded as 0000. It is followed by T_MRD cycles before the next command or before ready.
- R6: With REF_FIRST=1 the order is precharge, refreshes, mode load. With REF_FIRST=0 the order is precharge, mode load, refreshes.
- R7: The mode load puts on addr_o the value that mode_op_i held at the first rising edge after reset release. Later changes of mode_op_i have no effect.
- R8: Every cycle that is not a command cycle carries NOP.
- R9: init_done_o rises in bus cycle max(last command cycle + its recovery, LOCK_CYC). It stays high until reset.
- R10: cke_o is high at all times. dqm_o is all ones while init_done_o is low and all zeros once it is high.
- R11: Asserting rst_ni low at any point returns the pins to NOP and clears init_done_o. The next release restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_op_i | input | ADDR_W | Operation code for the mode register load |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address pins |
| ba_o | output | BA_W | Bank select pins |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | DM_W | Data byte masks |
| init_done_o | output | 1 | Device ready, sticky until reset |

## Verification
Some properties are checked by assertions on every cycle:
- NOP on the pins throughout the pause.
- Bit 10 set on every precharge.
- At least one NOP after every command.
- Ready never raised before the settling count has expired, and ready staying high once set.
- The captured operation code never changing after its capture.

Other behaviour can only be shown by the bench's scenarios. The bench runs two small configurations, one for each ordering: in one the command sequence sets the ready time, in the other the settling count does. In each run it compares every cycle against a timeline computed from the parameters. Those scenarios show the exact command cycles, the number of refreshes, the ordering choice, the capture of the operation code, and the restart after a second reset.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;
  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS} cmd_e;
  typedef enum logic [1:0] {ST_PAUSE, ST_CMD, ST_GAP, ST_FIN} st_e;
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;
endpackage

// File: rtl/sbs_cmd_drive.sv
module sbs_cmd_drive
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] op_i,
  output pins_t             pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);
  always_comb begin
    pins_o = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    addr_o = '0;
    ba_o   = '0;
    unique case (cmd_i)
      CMD_PRE: begin
        pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
        addr_o[AP_BIT] = 1'b1;
      end
      CMD_REF: pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: begin
        pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
        addr_o = op_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sbs_down_timer.sv
module sbs_down_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(RST_VAL);
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sbs_lock_timer.sv
module sbs_lock_timer #(
  parameter int LIMIT = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic lock_o
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cnt_q != W'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign lock_o = (cnt_q == W'(LIMIT));

  // a_r9_lock_monotone
  a_r9_lock_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int DM_W      = 8,
  parameter int PAUSE_CYC = 25000,
  parameter int LOCK_CYC  = 125000,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2,
  parameter int REF_CNT   = 8,
  parameter bit REF_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_op_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              cke_o,
  output logic [DM_W-1:0]   dqm_o,
  output logic              init_done_o
);
  localparam int MAX_REC = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                         : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int MAX_T   = (PAUSE_CYC > MAX_REC) ? PAUSE_CYC : MAX_REC;
  localparam int TW      = $clog2(MAX_T + 1);
  localparam int RW      = $clog2(REF_CNT + 1);

  st_e               st_q, st_d;
  cmd_e              cur_q, cur_d, drv_cmd;
  logic [RW-1:0]     ref_left_q;
  logic [ADDR_W-1:0] op_q;
  logic              armed_q;
  logic              tmr_load, tmr_zero, lock_ok;
  logic [TW-1:0]     tmr_val;
  pins_t             pins;

  sbs_down_timer #(.W(TW), .RST_VAL(PAUSE_CYC - 1)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero));

  sbs_lock_timer #(.LIMIT(LOCK_CYC)) u_lock (
    .clk_i, .rst_ni, .lock_o(lock_ok));

  // recovery counts are loaded as T-2: one cycle is the command, one the final wait
  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_PAUSE: if (tmr_zero) begin
        st_d  = ST_CMD;
        cur_d = CMD_PRE;
      end
      ST_CMD: begin
        st_d     = ST_GAP;
        tmr_load = 1'b1;
        unique case (cur_q)
          CMD_PRE: tmr_val = TW'(T_RP - 2);
          CMD_REF: tmr_val = TW'(T_RC - 2);
          default: tmr_val = TW'(T_MRD - 2);
        endcase
      end
      ST_GAP: if (tmr_zero) begin
        st_d = ST_CMD;
        unique case (cur_q)
          CMD_PRE: cur_d = REF_FIRST ? CMD_REF : CMD_MRS;
          CMD_REF: begin
            if (ref_left_q != '0) cur_d = CMD_REF;
            else if (REF_FIRST)   cur_d = CMD_MRS;
            else                  st_d  = ST_FIN;
          end
          default: begin
            if (REF_FIRST) st_d  = ST_FIN;
            else           cur_d = CMD_REF;
          end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_PAUSE;
      cur_q      <= CMD_NOP;
      ref_left_q <= RW'(REF_CNT);
      op_q       <= '0;
      armed_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      if (st_q == ST_CMD && cur_q == CMD_REF) ref_left_q <= ref_left_q - 1'b1;
      if (!armed_q) begin
        op_q    <= mode_op_i;
        armed_q <= 1'b1;
      end
    end
  end

  assign drv_cmd = (st_q == ST_CMD) ? cur_q : CMD_NOP;

  sbs_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(10)) u_drv (
    .cmd_i(drv_cmd), .op_i(op_q), .pins_o(pins), .addr_o(addr_o), .ba_o(ba_o));

  assign cs_no       = pins.cs_n;
  assign ras_no      = pins.ras_n;
  assign cas_no      = pins.cas_n;
  assign we_no       = pins.we_n;
  assign init_done_o = (st_q == ST_FIN) && lock_ok;
  assign cke_o       = 1'b1;
  assign dqm_o       = {DM_W{~init_done_o}};

  // R1
  a_r1_pause_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAUSE) |-> (cs_no == 1'b0 && ras_no && cas_no && we_no));
  // R2
  a_r2_pre_all_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !ras_no && cas_no && !we_no) |-> addr_o[10]);
  // R8
  a_r8_nop_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ras_no && cas_no && we_no) |=> (ras_no && cas_no && we_no));
  // R9
  a_r9_done_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> lock_ok);
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  // R7
  a_r7_op_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(op_q));
  // R10
  a_r10_mask_tracks_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dqm_o[0]) |-> $rose(init_done_o));
endmodule

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;
  localparam int AW = 13, BW = 2, DW = 8;
  localparam int P = 20, RP = 3, RC = 7, MRD = 2, N = 8;
  localparam int L0 = 50, L1 = 200;
  localparam int NC = 230;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] op;
  logic cs0, ras0, cas0, we0, cke0, dn0, cs1, ras1, cas1, we1, cke1, dn1;
  logic [AW-1:0] a0, a1;
  logic [BW-1:0] b0, b1;
  logic [DW-1:0] m0, m1;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sdram_boot_seq #(.ADDR_W(AW), .BA_W(BW), .DM_W(DW), .PAUSE_CYC(P), .LOCK_CYC(L0),
    .T_RP(RP), .T_RC(RC), .T_MRD(MRD), .REF_CNT(N), .REF_FIRST(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_op_i(op), .cs_no(cs0), .ras_no(ras0), .cas_no(cas0),
    .we_no(we0), .addr_o(a0), .ba_o(b0), .cke_o(cke0), .dqm_o(m0), .init_done_o(dn0));

  sdram_boot_seq #(.ADDR_W(AW), .BA_W(BW), .DM_W(DW), .PAUSE_CYC(P), .LOCK_CYC(L1),
    .T_RP(RP), .T_RC(RC), .T_MRD(MRD), .REF_CNT(N), .REF_FIRST(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .mode_op_i(op), .cs_no(cs1), .ras_no(ras1), .cas_no(cas1),
    .we_no(we1), .addr_o(a1), .ba_o(b1), .cke_o(cke1), .dqm_o(m1), .init_done_o(dn1));

  task automatic chk(string req, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", req, $time, act, exp);
    end
  endtask

  // 0 NOP, 1 PRE, 2 REF, 3 MRS
  function automatic int exp_cmd(int n, bit rf);
    int base = P + RP;
    int b2 = base + MRD;
    if (n == P) return 1;
    if (rf) begin
      if (n >= base && n < base + N*RC && (n - base) % RC == 0) return 2;
      if (n == base + N*RC) return 3;
    end else begin
      if (n == base) return 3;
      if (n >= b2 && n < b2 + N*RC && (n - b2) % RC == 0) return 2;
    end
    return 0;
  endfunction

  function automatic int dec(logic c, logic r, logic s, logic w);
    case ({c, r, s, w})
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 9;
    endcase
  endfunction

  task automatic chk_cycle(int n, bit rf, int lk, logic c, logic r, logic s, logic w,
                           logic [AW-1:0] a, logic [BW-1:0] b, logic ck, logic [DW-1:0] m,
                           logic d, logic [AW-1:0] opx);
    int e = exp_cmd(n, rf);
    int seq_end = P + RP + N*RC + MRD;
    int dn = (seq_end > lk) ? seq_end : lk;
    int got = dec(c, r, s, w);
    string rq;
    if (e == 0) rq = (n < P) ? "R1" : "R8";
    else if (e == 1) rq = "R2";
    else if (e == 2) rq = "R4";
    else rq = "R5";
    chk(rq, got == e, got, e);
    if (e == 1) chk("R2", a == 13'h0400 && b == '0, int'(a), 'h400);
    if (e == 3) chk("R7", a == opx, int'(a), int'(opx));
    chk("R9", d == (n >= dn), int'(d), int'(n >= dn));
    chk("R10", ck == 1'b1 && m == ((n >= dn) ? 8'h00 : 8'hFF), int'(m), (n >= dn) ? 0 : 255);
  endtask

  // R3 R6 covered by the timeline in exp_cmd; R11 by the second run
  task automatic run(logic [AW-1:0] v);
    @(negedge clk);
    #1;
    chk("R11", dn0 == 0 && dn1 == 0 && dec(cs0, ras0, cas0, we0) == 0
               && dec(cs1, ras1, cas1, we1) == 0 && m0 == 8'hFF && cke0, int'(dn0), 0);
    @(negedge clk);
    rst_n = 1'b1;
    op = v;
    for (int n = 0; n <= NC; n++) begin
      #1;
      if (n == 1) op = ~v;
      chk_cycle(n, 1'b1, L0, cs0, ras0, cas0, we0, a0, b0, cke0, m0, dn0, v);
      chk_cycle(n, 1'b0, L1, cs1, ras1, cas1, we1, a1, b1, cke1, m1, dn1, v);
      @(negedge clk);
    end
    rst_n = 1'b0;
  endtask

  initial begin
    op = '0;
    run(13'h0033);
    run(13'h0127);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule